// File: doc/BRIEF.md
# Interrupt vector dispatch unit

This block turns a pending event vector into a handler entry point. It holds a descriptor table with one entry for each of the 256 vectors, and entry N describes vector N. Vectors 0 to 31 belong to processor exceptions. Vectors 32 to 255 are free for software to assign. Each entry holds a code selector, a 32-bit handler offset, a target privilege ring, a present bit and a gate type. The table is loaded through a simple write port, with address, fields and a write enable. Every entry comes out of reset marked not present.

A request carries the vector, its origin and the current privilege level. The origin is an external IRQ, a processor exception or a software-raised interrupt. An entry that is not present does not dispatch, and the vector is replaced by the protection-fault vector 13. A software-raised request is also replaced by vector 13 when its descriptor ring is more privileged than the caller. Hardware-originated requests skip that privilege check. One cycle after the request, the block presents the resolved vector and the selector, offset and ring of that vector's entry. It also presents a flag that tells the core to clear its interrupt-enable bit, which is set for interrupt-type gates and clear for trap-type gates. Fetching from memory, pushing state onto a stack and returning from a handler are handled elsewhere.

Top module: `vec_dispatch`

## Requirements
- R1: After reset, `out_valid` and `out_clr_if` are low and every descriptor entry is not present.
- R2: A cycle with `cfg_we` high stores the selector, offset, ring, present bit and gate type (`cfg_trap`: 1 = trap/exception gate, 0 = interrupt gate) into the entry at `cfg_addr`. A later request for that vector reports those stored fields.
- R3: `out_valid` is high in exactly the cycle after each cycle with `req_valid` high and is low otherwise, so back-to-back requests give back-to-back results.
- R4: A request whose entry is not present yields `out_vec` = 13, with the selector, offset, ring and gate of entry 13.
- R5: A software-raised request (`req_src` = 2'b10) whose entry ring is numerically lower than `req_cpl` yields `out_vec` = 13, with entry 13's fields.
- R6: A software-raised request to a present entry whose ring is numerically equal to or greater than `req_cpl` dispatches to its own vector.
- R7: External IRQs (`req_src` = 2'b00) and processor exceptions (`req_src` = 2'b01) dispatch to a present entry whatever its ring and `req_cpl` are.
- R8: `out_clr_if` is high with a result whose resolved entry is an interrupt gate, low with a trap gate, and low whenever `out_valid` is low.
- R9: When a table write and a request fall in the same cycle, the request resolves against the table contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Table write enable |
| cfg_addr | input | 8 | Entry to write |
| cfg_sel | input | 16 | Code selector to store |
| cfg_off | input | 32 | Handler offset to store |
| cfg_ring | input | 2 | Target ring to store |
| cfg_present | input | 1 | Present bit to store |
| cfg_trap | input | 1 | Gate type to store: 1 trap, 0 interrupt |
| req_valid | input | 1 | Request strobe |
| req_vec | input | 8 | Requested vector |
| req_src | input | 2 | Origin: 00 IRQ, 01 exception, 10 software |
| req_cpl | input | 2 | Current privilege level of the requester |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_vec | output | 8 | Resolved vector |
| out_sel | output | 16 | Code selector of the resolved entry |
| out_off | output | 32 | Handler offset of the resolved entry |
| out_ring | output | 2 | Target ring of the resolved entry |
| out_clr_if | output | 1 | Clear the interrupt-enable flag on entry |

## Verification
The assertions check on every cycle that a result follows each request by exactly one cycle. They also check that the only vector that can stand in for a request is 13, that a software request which dispatches to its own vector never reaches a more privileged ring than its caller, and that the clear-IF flag appears only together with a result. Only the bench scenarios can show that the right descriptor fields come back, because that depends on what was written earlier through the table port. The same holds for entries that start out not present, for the bypass of the privilege check by IRQs and exceptions, and for a write and a read falling in the same cycle. The scoreboard predicts each result from its own shadow copy of the table.

// File: rtl/vec_dispatch.sv
module vec_dispatch #(
  parameter int NVEC    = 256,
  parameter int SEL_W   = 16,
  parameter int OFF_W   = 32,
  parameter int RING_W  = 2,
  parameter int GPF_VEC = 13
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [$clog2(NVEC)-1:0]  cfg_addr,
  input  logic [SEL_W-1:0]         cfg_sel,
  input  logic [OFF_W-1:0]         cfg_off,
  input  logic [RING_W-1:0]        cfg_ring,
  input  logic                     cfg_present,
  input  logic                     cfg_trap,
  input  logic                     req_valid,
  input  logic [$clog2(NVEC)-1:0]  req_vec,
  input  logic [1:0]               req_src,
  input  logic [RING_W-1:0]        req_cpl,
  output logic                     out_valid,
  output logic [$clog2(NVEC)-1:0]  out_vec,
  output logic [SEL_W-1:0]         out_sel,
  output logic [OFF_W-1:0]         out_off,
  output logic [RING_W-1:0]        out_ring,
  output logic                     out_clr_if
);
  localparam int VW = $clog2(NVEC);
  localparam logic [1:0] SRC_SW = 2'b10;
  localparam logic [VW-1:0] FAULT_VEC = VW'(GPF_VEC);

  logic [SEL_W-1:0]  t_sel  [NVEC];
  logic [OFF_W-1:0]  t_off  [NVEC];
  logic [RING_W-1:0] t_ring [NVEC];
  logic [NVEC-1:0]   t_trap;
  logic [NVEC-1:0]   t_pres;

  always_ff @(posedge clk) begin
    if (cfg_we) begin
      t_sel[cfg_addr]  <= cfg_sel;
      t_off[cfg_addr]  <= cfg_off;
      t_ring[cfg_addr] <= cfg_ring;
      t_trap[cfg_addr] <= cfg_trap;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      t_pres <= '0;
    else if (cfg_we) t_pres[cfg_addr] <= cfg_present;
  end

  logic          priv_bad, fault;
  logic [VW-1:0] dvec;

  assign priv_bad = (req_src == SRC_SW) && (t_ring[req_vec] < req_cpl);
  assign fault    = !t_pres[req_vec] || priv_bad;
  assign dvec     = fault ? FAULT_VEC : req_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_clr_if <= 1'b0;
    end else begin
      out_valid  <= req_valid;
      out_clr_if <= req_valid && !t_trap[dvec];
    end
  end

  always_ff @(posedge clk) begin
    if (req_valid) begin
      out_vec  <= dvec;
      out_sel  <= t_sel[dvec];
      out_off  <= t_off[dvec];
      out_ring <= t_ring[dvec];
    end
  end

  assert_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);

  assert_no_orphan_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(req_valid));

  assert_only_fault_subst_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_vec != FAULT_VEC) |-> out_vec == $past(req_vec));

  assert_sw_ring_ok_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_vec != FAULT_VEC && $past(req_src) == SRC_SW)
      |-> out_ring >= $past(req_cpl));

  assert_clr_with_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_clr_if |-> out_valid);
endmodule

// File: tb/vec_dispatch_bench.sv
module vec_dispatch_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        cfg_we = 0, cfg_present = 0, cfg_trap = 0, req_valid = 0;
  logic [7:0]  cfg_addr = 0, req_vec = 0;
  logic [15:0] cfg_sel = 0;
  logic [31:0] cfg_off = 0;
  logic [1:0]  cfg_ring = 0, req_src = 0, req_cpl = 0;
  logic        out_valid, out_clr_if;
  logic [7:0]  out_vec;
  logic [15:0] out_sel;
  logic [31:0] out_off;
  logic [1:0]  out_ring;

  vec_dispatch u_vec_dispatch (.*);

  typedef struct packed {
    logic [7:0]  vec;
    logic [15:0] sel;
    logic [31:0] off;
    logic [1:0]  ring;
    logic        clr;
    logic [31:0] cyc;
  } exp_t;

  exp_t  sb_q[$];
  string tag_q[$];
  int checks = 0, fails = 0, cyc = 0;

  logic [15:0] m_sel  [256];
  logic [31:0] m_off  [256];
  logic [1:0]  m_ring [256];
  logic        m_pres [256];
  logic        m_trap [256];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [7:0] a, input logic [15:0] s, input logic [31:0] o,
                         input logic [1:0] r, input logic p, input logic t);
    cfg_we = 1; cfg_addr = a; cfg_sel = s; cfg_off = o; cfg_ring = r;
    cfg_present = p; cfg_trap = t;
  endtask

  task automatic commit_cfg();
    if (cfg_we) begin
      m_sel[cfg_addr] = cfg_sel; m_off[cfg_addr] = cfg_off; m_ring[cfg_addr] = cfg_ring;
      m_pres[cfg_addr] = cfg_present; m_trap[cfg_addr] = cfg_trap;
    end
  endtask

  task automatic set_req(input logic [7:0] v, input logic [1:0] src, input logic [1:0] cpl, input string tag);
    exp_t e;
    logic [7:0] d;
    d = v;
    if (!m_pres[v] || (src == 2'b10 && m_ring[v] < cpl)) d = 8'd13;
    e.vec = d; e.sel = m_sel[d]; e.off = m_off[d]; e.ring = m_ring[d];
    e.clr = !m_trap[d]; e.cyc = cyc + 1;
    sb_q.push_back(e); tag_q.push_back(tag);
    req_valid = 1; req_vec = v; req_src = src; req_cpl = cpl;
  endtask

  task automatic step();
    @(posedge clk);
    commit_cfg();
    #1;
    cfg_we = 0; req_valid = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] s, input logic [31:0] o,
                    input logic [1:0] r, input logic p, input logic t);
    set_cfg(a, s, o, r, p, t); step();
  endtask

  task automatic rq(input logic [7:0] v, input logic [1:0] src, input logic [1:0] cpl, input string tag);
    set_req(v, src, cpl, tag); step();
  endtask

  always @(negedge clk) if (rst_n) begin
    if (out_valid) begin
      if (sb_q.size() == 0) chk(0, "R3 unexpected out_valid", 1, 0);
      else begin
        exp_t e; string t;
        e = sb_q.pop_front(); t = tag_q.pop_front();
        chk(cyc == e.cyc, {t, " R3 timing"}, cyc, e.cyc);
        chk(out_vec == e.vec, {t, " vec"}, out_vec, e.vec);
        chk(out_sel == e.sel, {t, " sel R2"}, out_sel, e.sel);
        chk(out_off == e.off, {t, " off R2"}, out_off, e.off);
        chk(out_ring == e.ring, {t, " ring R2"}, out_ring, e.ring);
        chk(out_clr_if == e.clr, {t, " clr_if R8"}, out_clr_if, e.clr);
      end
    end else begin
      if (out_clr_if) chk(0, "R8 clr_if without valid", 1, 0);
    end
  end

  initial begin
    fork
      begin
        #400000;
        chk(0, "watchdog expired", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    join_none
    for (int i = 0; i < 256; i++) begin
      m_pres[i] = 0; m_sel[i] = 0; m_off[i] = 0; m_ring[i] = 0; m_trap[i] = 0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(out_valid == 0, "R1 out_valid after reset", out_valid, 0);
    chk(out_clr_if == 0, "R1 clr_if after reset", out_clr_if, 0);
    // R1: only entry 13 loaded; all others not present
    wr(8'd13, 16'h0008, 32'hC000_0D00, 2'd0, 1, 0);
    rq(8'd40, 2'b00, 2'd0, "R1 R4 unloaded irq");
    rq(8'd14, 2'b01, 2'd0, "R1 R4 unloaded exc");
    step();
    // R2 R7 R8: load entries
    wr(8'd14, 16'h0008, 32'hC000_1400, 2'd0, 1, 1);
    wr(8'd3,  16'h0008, 32'hC000_0300, 2'd3, 1, 1);
    wr(8'd48, 16'h0010, 32'hC000_3000, 2'd0, 1, 1);
    wr(8'd32, 16'h0018, 32'hC000_2000, 2'd0, 1, 0);
    wr(8'd200, 16'h0020, 32'h1234_5678, 2'd1, 1, 0);
    rq(8'd14, 2'b01, 2'd3, "R7 exc bypass");
    rq(8'd32, 2'b00, 2'd3, "R7 R8 irq bypass");
    rq(8'd200, 2'b00, 2'd2, "R2 R7 irq");
    step();
    // R5 / R6 software
    rq(8'd48, 2'b10, 2'd3, "R5 sw denied");
    rq(8'd3,  2'b10, 2'd3, "R6 sw allowed eq");
    rq(8'd48, 2'b10, 2'd0, "R6 sw allowed kernel");
    rq(8'd200, 2'b10, 2'd1, "R6 sw eq ring1");
    rq(8'd200, 2'b10, 2'd2, "R5 sw denied ring1");
    rq(8'd99, 2'b10, 2'd0, "R4 sw not present");
    step();
    // R9: write and request in same cycle
    set_cfg(8'd99, 16'h0030, 32'hDEAD_0099, 2'd0, 1, 1);
    set_req(8'd99, 2'b00, 2'd0, "R9 old contents");
    step();
    rq(8'd99, 2'b00, 2'd0, "R9 new contents");
    set_cfg(8'd32, 16'h0018, 32'hC000_2000, 2'd0, 0, 0);
    set_req(8'd32, 2'b00, 2'd0, "R9 still present");
    step();
    rq(8'd32, 2'b00, 2'd0, "R4 removed entry");
    // R8 fault vector as trap gate
    wr(8'd13, 16'h0008, 32'hC000_0D10, 2'd0, 1, 1);
    rq(8'd7, 2'b01, 2'd0, "R4 R8 fault trap gate");
    repeat (3) step();
    chk(sb_q.size() == 0, "R3 results outstanding", sb_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule